// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface. It takes the memory from power-on to an idle state that is ready for normal use. After reset it drives NOP commands, with clock enable and every byte mask held high, for a start-up pause of at least 200 µs. It then precharges all banks and waits out the row-precharge recovery. Next it runs the auto-refresh burst and the mode-register write, in an order picked by a parameter. The mode word comes from a parameter, and each command is followed by its recovery gap of NOPs.

Once the last recovery gap has elapsed, the block raises `initDone` and releases the byte masks, and the normal controller takes over the command bus. From then on a free-running interval timer pulses `refreshTick`. The interval is 64 ms divided by 4096 rows, converted to clocks and rounded down, so the controller can schedule periodic refreshes.

All cycle counts are derived from the clock period parameter. Pause and recovery times round up; the refresh interval rounds down. All command, address and mask outputs are registered, so each appears one clock after the internal step that chose it.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset is released, the command pins carry NOP (csN,rasN,casN,weN = 0,1,1,1) for exactly PAUSE_CYC+1 cycles. PAUSE_CYC is 20000 at the default 10 ns clock: 200 µs rounded up, plus one cycle of output-register latency.
- R2: `cke` is high at all times. `dqm` is all ones while `initDone` is low and all zeros once it is high.
- R3: The first command after the pause is precharge-all (0,0,1,0), with only address bit 10 set and the bank address zero.
- R4: The mode-register write (0,0,0,0) carries MODE_WORD (default 12'h032) on the address pins, with the bank address zero.
- R5: Exactly NUM_REF (8) auto-refresh commands (0,0,0,1) are issued, each with address and bank address zero.
- R6: Precharge-all is followed by TRP_CYC (2) NOP cycles, each auto-refresh by TRC_CYC (7) and the mode write by 2. With REF_FIRST=1 the refresh burst precedes the mode write; with REF_FIRST=0 it follows it.
- R7: `initDone` is low until the cycle after the last recovery NOP. From that cycle on it stays high.
- R8: `refreshTick` is a one-cycle pulse that occurs only while `initDone` is high. The first pulse falls in the REFI_CYC-th cycle of `initDone` (REFI_CYC = 1562 by default), and later pulses follow every REFI_CYC cycles.
- R9: Asserting `rstN` low at any point, including mid-burst or in a tick cycle, at once forces NOP, address zero, all-ones `dqm`, low `initDone` and no tick. On release the full sequence restarts from the pause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset, restarts the sequence |
| cke | output | 1 | SDRAM clock enable, held high |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address, zero throughout |
| addr | output | ADDR_W | Address pins: bit 10 on precharge-all, mode word on mode write |
| dqm | output | DQM_W | Byte masks, all ones until ready |
| initDone | output | 1 | Sequence complete, controller may take the bus |
| refreshTick | output | 1 | One-cycle periodic refresh request pulse |

## Verification
Reset can land in the same cycle as other activity: in the middle of the refresh burst, and in the very cycle a periodic refresh pulse is visible. The bench provokes both by dropping `rstN` right after the observed pulse, and at a point 30 cycles into the post-pause command stream. Both ordering variants run side by side in the bench. It judges that the pulse and ready vanish at once, and that the whole pause-precharge-refresh-mode sequence then replays cycle for cycle against its behavioural model. It also covers the cycle where the final refresh recovery ends together with the refresh count reaching its target, which must branch to the mode write or to ready depending on the order.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command encoding on {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdramCmd_e;

  // Which recovery window the shared wait counter is timing
  typedef enum logic [1:0] {
    WAIT_PAUSE = 2'd0,
    WAIT_TRP   = 2'd1,
    WAIT_TRC   = 2'd2,
    WAIT_MRD   = 2'd3
  } waitSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic      waitClr;
    waitSel_e  waitSel;
    logic      refInc;
    sdramCmd_e cmd;
    logic      ready;
  } ctrlStrobe_t;

  // Nanoseconds to clock cycles, rounding up
  function automatic int cyclesCeil(input int ns, input int periodPs);
    longint num;
    num = longint'(ns) * 64'd1000 + longint'(periodPs) - 64'd1;
    return int'(num / longint'(periodPs));
  endfunction

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter bit REF_FIRST = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        waitDone,
  input  logic        refsDone,
  output ctrlStrobe_t strobe
);

  typedef enum logic [2:0] {
    ST_PAUSE, ST_PRE, ST_TRP, ST_REF, ST_TRC, ST_MRS, ST_MRD, ST_DONE
  } state_e;

  state_e state, nextState;
  state_e afterPrecharge, afterBurst, afterMode;

  // The parameter picks the step order
  generate
    if (REF_FIRST) begin : g_refFirst
      assign afterPrecharge = ST_REF;
      assign afterBurst     = ST_MRS;
      assign afterMode      = ST_DONE;
    end else begin : g_modeFirst
      assign afterPrecharge = ST_MRS;
      assign afterBurst     = ST_DONE;
      assign afterMode      = ST_REF;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PAUSE;
    else       state <= nextState;
  end

  always_comb begin
    strobe         = '0;
    strobe.cmd     = CMD_NOP;
    strobe.waitSel = WAIT_PAUSE;
    nextState      = state;
    unique case (state)
      ST_PAUSE: begin
        strobe.waitSel = WAIT_PAUSE;
        if (waitDone) begin
          strobe.waitClr = 1'b1;
          nextState      = ST_PRE;
        end
      end
      ST_PRE: begin
        strobe.cmd     = CMD_PRE;
        strobe.waitClr = 1'b1;
        nextState      = ST_TRP;
      end
      ST_TRP: begin
        strobe.waitSel = WAIT_TRP;
        if (waitDone) begin
          strobe.waitClr = 1'b1;
          nextState      = afterPrecharge;
        end
      end
      ST_REF: begin
        strobe.cmd     = CMD_REF;
        strobe.refInc  = 1'b1;
        strobe.waitClr = 1'b1;
        nextState      = ST_TRC;
      end
      ST_TRC: begin
        strobe.waitSel = WAIT_TRC;
        if (waitDone) begin
          strobe.waitClr = 1'b1;
          nextState      = refsDone ? afterBurst : ST_REF;
        end
      end
      ST_MRS: begin
        strobe.cmd     = CMD_MRS;
        strobe.waitClr = 1'b1;
        nextState      = ST_MRD;
      end
      ST_MRD: begin
        strobe.waitSel = WAIT_MRD;
        if (waitDone) begin
          strobe.waitClr = 1'b1;
          nextState      = afterMode;
        end
      end
      ST_DONE: begin
        strobe.ready   = 1'b1;
        strobe.waitClr = 1'b1;
      end
      default: nextState = ST_PAUSE;
    endcase
  end

endmodule

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BA_W      = 2,
  parameter int DQM_W     = 4,
  parameter int AP_BIT    = 10,
  parameter int PAUSE_CYC = 20000,
  parameter int TRP_CYC   = 2,
  parameter int TRC_CYC   = 7,
  parameter int MRD_CYC   = 2,
  parameter int NUM_REF   = 8,
  parameter logic [ADDR_W-1:0] MODE_WORD = 12'h032
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  output logic              waitDone,
  output logic              refsDone,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic [DQM_W-1:0]  dqm,
  output logic              initDone
);

  localparam int MAX_A    = (PAUSE_CYC > TRC_CYC) ? PAUSE_CYC : TRC_CYC;
  localparam int MAX_B    = (TRP_CYC > MRD_CYC) ? TRP_CYC : MRD_CYC;
  localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int WAIT_W   = $clog2(MAX_WAIT + 1);
  localparam int REF_W    = $clog2(NUM_REF + 1);
  localparam int NUM_WIN  = 4;

  logic [WAIT_W-1:0] waitCnt;
  logic [WAIT_W-1:0] limitTab [NUM_WIN];
  logic [REF_W-1:0]  refCnt;
  sdramCmd_e         cmdQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DQM_W-1:0]  dqmQ;
  logic              readyQ;

  // Terminal count of each recovery window, indexed by waitSel_e
  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_limit
      localparam int LEN = (w == int'(WAIT_PAUSE)) ? PAUSE_CYC :
                           (w == int'(WAIT_TRP))   ? TRP_CYC   :
                           (w == int'(WAIT_TRC))   ? TRC_CYC   : MRD_CYC;
      assign limitTab[w] = WAIT_W'(LEN - 1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               waitCnt <= '0;
    else if (strobe.waitClr) waitCnt <= '0;
    else                     waitCnt <= waitCnt + 1'b1;
  end

  assign waitDone = (waitCnt == limitTab[strobe.waitSel]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              refCnt <= '0;
    else if (strobe.refInc) refCnt <= refCnt + 1'b1;
  end

  assign refsDone = (refCnt == REF_W'(NUM_REF));

  // Registered pin drivers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ   <= CMD_NOP;
      addrQ  <= '0;
      dqmQ   <= '1;
      readyQ <= 1'b0;
    end else begin
      cmdQ   <= strobe.cmd;
      dqmQ   <= strobe.ready ? '0 : '1;
      readyQ <= strobe.ready;
      unique case (strobe.cmd)
        CMD_PRE: addrQ <= ADDR_W'(1) << AP_BIT;
        CMD_MRS: addrQ <= MODE_WORD;
        default: addrQ <= '0;
      endcase
    end
  end

  assign {csN, rasN, casN, weN} = cmdQ;
  assign addr     = addrQ;
  assign ba       = '0;
  assign dqm      = dqmQ;
  assign initDone = readyQ;

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int REFI_CYC = 1562
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  output logic tick
);

  localparam int CNT_W = $clog2(REFI_CYC + 1);

  logic [CNT_W-1:0] intervalCnt;
  logic             atEnd;

  assign atEnd = (intervalCnt == CNT_W'(REFI_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       intervalCnt <= '0;
    else if (!enable) intervalCnt <= '0;
    else if (atEnd)   intervalCnt <= '0;
    else              intervalCnt <= intervalCnt + 1'b1;
  end

  assign tick = enable && atEnd;

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int  CLK_PERIOD_PS     = 10000,
  parameter int  PAUSE_NS          = 200000,
  parameter int  TRP_NS            = 20,
  parameter int  TRC_NS            = 62,
  parameter int  MRD_CYC           = 2,
  parameter int  NUM_REF           = 8,
  parameter int  REFRESH_WINDOW_NS = 64000000,
  parameter int  REFRESH_ROWS      = 4096,
  parameter bit  REF_FIRST         = 1'b1,
  parameter int  ADDR_W            = 12,
  parameter int  BA_W              = 2,
  parameter int  DQM_W             = 4,
  parameter int  AP_BIT            = 10,
  parameter logic [ADDR_W-1:0] MODE_WORD = 12'h032
) (
  input  logic              clk,
  input  logic              rstN,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic [DQM_W-1:0]  dqm,
  output logic              initDone,
  output logic              refreshTick
);

  localparam int PAUSE_CYC = cyclesCeil(PAUSE_NS, CLK_PERIOD_PS);
  localparam int TRP_CYC   = cyclesCeil(TRP_NS, CLK_PERIOD_PS);
  localparam int TRC_CYC   = cyclesCeil(TRC_NS, CLK_PERIOD_PS);
  localparam int REFI_CYC  = int'((longint'(REFRESH_WINDOW_NS) * 64'd1000) /
                                  (longint'(REFRESH_ROWS) * longint'(CLK_PERIOD_PS)));

  ctrlStrobe_t strobe;
  logic        waitDone;
  logic        refsDone;

  sdram_init_ctrl #(
    .REF_FIRST(REF_FIRST)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .waitDone(waitDone),
    .refsDone(refsDone),
    .strobe  (strobe)
  );

  sdram_init_dp #(
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W),
    .DQM_W    (DQM_W),
    .AP_BIT   (AP_BIT),
    .PAUSE_CYC(PAUSE_CYC),
    .TRP_CYC  (TRP_CYC),
    .TRC_CYC  (TRC_CYC),
    .MRD_CYC  (MRD_CYC),
    .NUM_REF  (NUM_REF),
    .MODE_WORD(MODE_WORD)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .waitDone(waitDone),
    .refsDone(refsDone),
    .csN     (csN),
    .rasN    (rasN),
    .casN    (casN),
    .weN     (weN),
    .addr    (addr),
    .ba      (ba),
    .dqm     (dqm),
    .initDone(initDone)
  );

  sdram_refresh_timer #(
    .REFI_CYC(REFI_CYC)
  ) u_timer (
    .clk   (clk),
    .rstN  (rstN),
    .enable(initDone),
    .tick  (refreshTick)
  );

  assign cke = 1'b1;

endmodule

// File: rtl/sdram_init_checker.sv
module sdram_init_checker #(
  parameter int ADDR_W   = 12,
  parameter int BA_W     = 2,
  parameter int DQM_W    = 4,
  parameter int AP_BIT   = 10,
  parameter int REFI_CYC = 1562,
  parameter logic [ADDR_W-1:0] MODE_WORD = 12'h032
) (
  input logic              clk,
  input logic              rstN,
  input logic              cke,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic [DQM_W-1:0]  dqm,
  input logic              initDone,
  input logic              refreshTick
);

  localparam int GAP_W = $clog2(REFI_CYC + 1);

  logic [3:0]       pinCmd;
  logic [GAP_W-1:0] gapCnt;

  assign pinCmd = {csN, rasN, casN, weN};

  // Independent count of cycles since ready or since the last pulse
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            gapCnt <= '0;
    else if (!initDone)   gapCnt <= '0;
    else if (refreshTick) gapCnt <= '0;
    else                  gapCnt <= gapCnt + 1'b1;
  end

  // R2
  assert_masks_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> (cke && (dqm == {DQM_W{1'b1}})));

  // R3
  assert_precharge_all_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pinCmd == 4'b0010) |-> (addr == (ADDR_W'(1) << AP_BIT)) && (ba == '0));

  // R6: every issued command is followed by a NOP
  assert_recovery_nop_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pinCmd != 4'b0111) |=> (pinCmd == 4'b0111));

  // R4
  assert_mode_word_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pinCmd == 4'b0000) |-> (addr == MODE_WORD) && (ba == '0));

  // R5
  assert_refresh_addr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (pinCmd == 4'b0001) |-> (addr == '0) && (ba == '0));

  // R7
  assert_ready_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  // R7: nothing but NOP once ready
  assert_idle_after_ready_R7: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (pinCmd == 4'b0111));

  // R8
  assert_tick_needs_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    refreshTick |-> initDone);

  // R8
  assert_tick_period_R8: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> (refreshTick == (gapCnt == GAP_W'(REFI_CYC - 1))));

endmodule

bind sdram_init_seq sdram_init_checker #(
  .ADDR_W   (ADDR_W),
  .BA_W     (BA_W),
  .DQM_W    (DQM_W),
  .AP_BIT   (AP_BIT),
  .REFI_CYC (REFI_CYC),
  .MODE_WORD(MODE_WORD)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cke        (cke),
  .csN        (csN),
  .rasN       (rasN),
  .casN       (casN),
  .weN        (weN),
  .ba         (ba),
  .addr       (addr),
  .dqm        (dqm),
  .initDone   (initDone),
  .refreshTick(refreshTick)
);

// File: tb/sdram_init_seq_test.sv
module sdram_init_seq_test;

  localparam int PAUSE = 20000;
  localparam int TRP   = 2;
  localparam int TRC   = 7;
  localparam int MRD   = 2;
  localparam int NREF  = 8;
  localparam int REFI  = 1562;
  localparam logic [11:0] MODE = 12'h032;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic        ckeA, csA, rasA, casA, weA, rdyA, tickA;
  logic [1:0]  baA;
  logic [11:0] addrA;
  logic [3:0]  dqmA;
  logic        ckeB, csB, rasB, casB, weB, rdyB, tickB;
  logic [1:0]  baB;
  logic [11:0] addrB;
  logic [3:0]  dqmB;

  sdram_init_seq #(.REF_FIRST(1'b1)) uut (
    .clk(clk), .rstN(rstN), .cke(ckeA), .csN(csA), .rasN(rasA), .casN(casA), .weN(weA),
    .ba(baA), .addr(addrA), .dqm(dqmA), .initDone(rdyA), .refreshTick(tickA));

  sdram_init_seq #(.REF_FIRST(1'b0)) uutAlt (
    .clk(clk), .rstN(rstN), .cke(ckeB), .csN(csB), .rasN(rasB), .casN(casB), .weN(weB),
    .ba(baB), .addr(addrB), .dqm(dqmB), .initDone(rdyB), .refreshTick(tickB));

  int checks = 0;
  int errors = 0;
  logic [3:0] seqA[$];
  logic [3:0] seqB[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Behavioural model: the command stream expected after reset release
  task automatic build(ref logic [3:0] q[$], input bit refFirst);
    q.delete();
    repeat (PAUSE) q.push_back(NOP);
    q.push_back(PRE);
    repeat (TRP) q.push_back(NOP);
    for (int pass = 0; pass < 2; pass++) begin
      if ((pass == 0) == refFirst) begin
        for (int r = 0; r < NREF; r++) begin
          q.push_back(REF);
          repeat (TRC) q.push_back(NOP);
        end
      end else begin
        q.push_back(MRS);
        repeat (MRD) q.push_back(NOP);
      end
    end
  endtask

  task automatic cmpInst(input int i, ref logic [3:0] q[$], input string nm,
                         input logic [3:0] cmd, input logic [11:0] addr,
                         input logic [1:0] ba, input logic cke, input logic [3:0] dqm,
                         input logic rdy, input logic tick);
    int len;
    logic [3:0] eCmd;
    logic [11:0] eAddr;
    bit eRdy, eTick;
    string tag;
    len   = q.size();
    eCmd  = (i <= len) ? q[i-1] : NOP;
    eRdy  = (i > len);
    eTick = eRdy && (((i - len - 1) % REFI) == REFI - 1);
    eAddr = (eCmd == PRE) ? 12'h400 : (eCmd == MRS) ? MODE : 12'h000;
    if (eCmd == PRE)      tag = "R3";
    else if (eCmd == REF) tag = "R5";
    else if (eCmd == MRS) tag = "R4";
    else if (i <= PAUSE)  tag = "R1";
    else                  tag = "R6";
    if (cmd != eCmd || addr != eAddr || ba != 2'b00) begin
      chk(cmd == eCmd, tag, {nm, " cmd"}, cmd, eCmd);
      chk(addr == eAddr, tag, {nm, " addr"}, addr, eAddr);
      chk(ba == 2'b00, tag, {nm, " ba"}, ba, 0);
    end else begin
      checks++;
    end
    chk(cke == 1'b1 && dqm == (eRdy ? 4'h0 : 4'hF), "R2", {nm, " cke/dqm"},
        {cke, dqm}, {1'b1, (eRdy ? 4'h0 : 4'hF)});
    chk(rdy == eRdy, "R7", {nm, " initDone"}, rdy, eRdy);
    chk(tick == eTick, "R8", {nm, " refreshTick"}, tick, eTick);
  endtask

  task automatic runSeq(input int n);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      cmpInst(i, seqA, "uut", {csA, rasA, casA, weA}, addrA, baA, ckeA, dqmA, rdyA, tickA);
      cmpInst(i, seqB, "uutAlt", {csB, rasB, casB, weB}, addrB, baB, ckeB, dqmB, rdyB, tickB);
    end
  endtask

  // R9: reset forces idle outputs at once, then released for a fresh run
  task automatic resetAndRestart();
    rstN = 1'b0;
    #1;
    chk({csA, rasA, casA, weA} == NOP && addrA == 0, "R9", "uut reset cmd", {csA, rasA, casA, weA}, NOP);
    chk({csB, rasB, casB, weB} == NOP && addrB == 0, "R9", "uutAlt reset cmd", {csB, rasB, casB, weB}, NOP);
    chk(!rdyA && !tickA && dqmA == 4'hF, "R9", "uut reset ready/tick/dqm", {rdyA, tickA, dqmA}, 6'h0F);
    chk(!rdyB && !tickB && dqmB == 4'hF, "R9", "uutAlt reset ready/tick/dqm", {rdyB, tickB, dqmB}, 6'h0F);
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int lenMax;
    build(seqA, 1'b1);
    build(seqB, 1'b0);
    lenMax = (seqA.size() > seqB.size()) ? seqA.size() : seqB.size();
    @(negedge clk);
    resetAndRestart();
    // R1 R3 R4 R5 R6 R7 R8: full sequence for both orders, then three refresh pulses
    runSeq(lenMax + 3 * REFI + 4);
    // R9: reset in the middle of the post-pause command stream
    resetAndRestart();
    runSeq(PAUSE + 30);
    resetAndRestart();
    runSeq(lenMax + REFI + 4);
    // R9: reset in the very cycle a refresh pulse is visible on uut
    resetAndRestart();
    runSeq(seqA.size() + REFI);
    chk(tickA == 1'b1, "R8", "uut tick before reset", tickA, 1);
    resetAndRestart();
    runSeq(PAUSE + 10);
    finishRun();
  end

endmodule